// File: doc/BRIEF.md
# Codec Interrupt Flag and Ramp Sequencer

This block is the interrupt core of an audio codec's control logic. It holds a six-bit event flag register, a mask register whose upper two bits select the output signalling form, a power standby register and a mute register. Two small sequencers stand in for analog and digital ramps, and each one raises its completion flag at the right moment.

The first sequencer models the headphone amplifier ramp and is started by changes of the headphone mute bit. The second models the DAC digital gain ramp and is started by changes of the DAC mute bit. The DAC ramp runs only while the DAC is out of standby. The flag register also collects a short-circuit event, which arrives as a one-clock input pulse, and a jack event, which is raised on either edge of an asynchronous jack-detect pin after synchronisation.

Software writes registers through a single-cycle write port and reads them through a combinational read port. A single interrupt line summarises the unmasked flags. Depending on the selected form, the line is a level of either polarity, or a one-clock pulse of either polarity for each newly raised flag.

Top module: `codec_irq_seq`

## Requirements
- R1: After reset, the power register (address 0) reads 0x03, meaning both stages are in standby. The mute register (address 1) reads 0x03, the flag register (address 2) reads 0x00, the mask register (address 3) reads 0x3F, and the interrupt line is low.
- R2: Flag register layout: bit 0 is gain-down done, bit 1 gain-up done, bit 2 ramp-down done, bit 3 ramp-up done, bit 4 short circuit, bit 5 jack event. Bit 6 reads the live synchronised jack level and bit 7 reads 0. Writing 1 to any of bits 5:0 clears that bit. Writing 0 leaves a bit unchanged, and bit 6 cannot be written.
- R3: A flag that is raised in the same cycle as a write-1 clear of that flag stays set.
- R4: When the headphone mute bit (address 1, bit 0) is cleared while the headphone standby bit (address 0, bit 0) is 0, the ramp-up flag is set exactly HP_RAMP_LEN clocks after the write edge. When the headphone stage is in standby, no up-ramp starts.
- R5: Setting the headphone mute bit starts a down-ramp regardless of power. The ramp-down flag is set HP_RAMP_LEN clocks after the write edge.
- R6: A change of the DAC mute bit (address 1, bit 1) starts a gain ramp only while the DAC standby bit (address 0, bit 1) is 0. After GAIN_RAMP_LEN clocks, the ramp sets gain-down done if the change was a mute and gain-up done if it was an unmute. Entering standby during a ramp aborts it, and no flag is set.
- R7: A mute change during a running ramp restarts that ramp in the new direction. Only the new direction's flag is set, a full ramp length after the new write.
- R8: Either edge of the jack input sets the jack event flag JACK_STAGES+1 clocks after it is captured. Bit 6 follows the synchronised level.
- R9: A one-clock short-circuit pulse sets flag bit 4.
- R10: A set mask bit (mask bits 5:0, same positions as the flags) keeps that flag from driving the interrupt. Clearing the mask bit while the flag is pending makes the interrupt active.
- R11: Mask bits 7:6 select the output form. 00 is an active-high level and 01 is an active-low level, both showing whether any unmasked flag is set.
- R12: Forms 10 and 11 give a one-clock high pulse or low pulse, respectively, in the clock after an unmasked flag goes from clear to set. A flag that is raised again while already set gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 2 | Write address: 0 power, 1 mute, 2 flags, 3 mask |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Combinational read data |
| jack_in | input | 1 | Asynchronous jack-detect level |
| short_pulse | input | 1 | One-clock short-circuit event |
| irq_o | output | 1 | Interrupt line in the selected form |

## Verification
The bench measures each ramp to the exact clock. A counter that is off by one, or a flag that is raised at the start of the ramp, fails the before-and-after pair of checks. It restarts the DAC ramp mid-flight and pulls the DAC into standby mid-flight: a sequencer that ignores the restart would raise the stale direction's flag, and one that ignores power would still complete. It lands a short-circuit pulse on the same edge as a write-1 clear of that flag, which a clear-wins design would lose. It also raises a flag that is already set while in pulse form, which a level-derived pulse would repeat.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int NFLAG  = 6;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PWR  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MUTE = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd3;

  typedef enum logic [1:0] {
    FORM_LVL_HI = 2'b00,
    FORM_LVL_LO = 2'b01,
    FORM_PLS_HI = 2'b10,
    FORM_PLS_LO = 2'b11
  } irq_form_e;

  // write-one-to-clear with new events taking priority
  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] cur,
                                                 input logic [NFLAG-1:0] clr,
                                                 input logic [NFLAG-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(input logic [NFLAG-1:0] flags,
                                       input logic [NFLAG-1:0] mask);
    return |(flags & ~mask);
  endfunction

  function automatic logic any_fresh(input logic [NFLAG-1:0] flags_old,
                                     input logic [NFLAG-1:0] set,
                                     input logic [NFLAG-1:0] mask);
    return |(set & ~flags_old & ~mask);
  endfunction
endpackage

// File: rtl/codec_ramp_seq.sv
module codec_ramp_seq #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_up,
  input  logic start_dn,
  input  logic run_ok,
  output logic done_up,
  output logic done_dn
);
  localparam int CW = $clog2(LEN + 1);

  logic          busy_q;
  logic          dir_dn_q;
  logic [CW-1:0] cnt_q;
  logic          start;
  logic          finish;

  assign start  = start_up | start_dn;
  assign finish = busy_q && (cnt_q == '0) && run_ok && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_dn_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!run_ok) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      dir_dn_q <= start_dn;
      cnt_q    <= CW'(LEN - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_up = finish && !dir_dn_q;
  assign done_dn = finish &&  dir_dn_q;

  // R7: a (re)start never completes on the following clock
  a_r7_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !(done_up || done_dn));
endmodule

// File: rtl/codec_jack_sync.sv
module codec_jack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jack_async,
  output logic jack_s,
  output logic jack_evt
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], jack_async};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign jack_s   = sh_q[STAGES-1];
  assign jack_evt = sh_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/codec_irq_drive.sv
module codec_irq_drive
  import codec_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags_q,
  input  logic [NFLAG-1:0] flags_d,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] mask_q,
  input  logic [NFLAG-1:0] mask_d,
  input  irq_form_e        form_q,
  input  irq_form_e        form_d,
  output logic             irq_o
);
  logic act_q;
  logic act_d;

  always_comb begin
    if (form_d[1]) act_d = any_fresh(flags_q, set_vec, mask_q);
    else           act_d = any_pending(flags_d, mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign irq_o = form_q[0] ? ~act_q : act_q;

  // R11: level forms track the unmasked pending flags
  a_r11_level_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (form_q == FORM_LVL_HI) |-> (irq_o == any_pending(flags_q, mask_q)));
  a_r11_level_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (form_q == FORM_LVL_LO) |-> (irq_o == !any_pending(flags_q, mask_q)));
endmodule

// File: rtl/codec_irq_seq.sv
module codec_irq_seq
  import codec_irq_pkg::*;
#(
  parameter int HP_RAMP_LEN   = 16,
  parameter int GAIN_RAMP_LEN = 16,
  parameter int JACK_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       jack_in,
  input  logic       short_pulse,
  output logic       irq_o
);
  logic [1:0]       pwr_q, mute_q;
  logic [NFLAG-1:0] flags_q, flags_d, flag_set, flag_clr;
  logic [7:0]       mask_q, mask_d;
  logic             pwr_wr, mute_wr, flag_wr, mask_wr;
  logic             hp_up_start, hp_dn_start, dac_up_start, dac_dn_start;
  logic             hp_up_done, hp_dn_done, dac_up_done, dac_dn_done;
  logic             jack_s, jack_evt;

  assign pwr_wr  = wr_en && (wr_addr == A_PWR);
  assign mute_wr = wr_en && (wr_addr == A_MUTE);
  assign flag_wr = wr_en && (wr_addr == A_FLAG);
  assign mask_wr = wr_en && (wr_addr == A_MASK);

  // headphone ramp: up needs power, down starts unconditionally
  assign hp_up_start  = mute_wr && mute_q[0] && !wr_data[0] && !pwr_q[0];
  assign hp_dn_start  = mute_wr && !mute_q[0] && wr_data[0];
  // DAC gain ramp: any change, only while powered
  assign dac_up_start = mute_wr && mute_q[1] && !wr_data[1] && !pwr_q[1];
  assign dac_dn_start = mute_wr && !mute_q[1] && wr_data[1] && !pwr_q[1];

  codec_ramp_seq #(.LEN(HP_RAMP_LEN)) u_hp_ramp (
    .clk(clk), .rst_n(rst_n),
    .start_up(hp_up_start), .start_dn(hp_dn_start), .run_ok(1'b1),
    .done_up(hp_up_done), .done_dn(hp_dn_done));

  codec_ramp_seq #(.LEN(GAIN_RAMP_LEN)) u_gain_ramp (
    .clk(clk), .rst_n(rst_n),
    .start_up(dac_up_start), .start_dn(dac_dn_start), .run_ok(!pwr_q[1]),
    .done_up(dac_up_done), .done_dn(dac_dn_done));

  codec_jack_sync #(.STAGES(JACK_STAGES)) u_jack (
    .clk(clk), .rst_n(rst_n), .jack_async(jack_in),
    .jack_s(jack_s), .jack_evt(jack_evt));

  assign flag_set = {jack_evt, short_pulse, hp_up_done, hp_dn_done,
                     dac_up_done, dac_dn_done};
  assign flag_clr = flag_wr ? wr_data[NFLAG-1:0] : '0;
  assign flags_d  = flag_next(flags_q, flag_clr, flag_set);
  assign mask_d   = mask_wr ? wr_data : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 2'b11;
      mute_q  <= 2'b11;
      flags_q <= '0;
      mask_q  <= 8'h3F;
    end else begin
      if (pwr_wr)  pwr_q  <= wr_data[1:0];
      if (mute_wr) mute_q <= wr_data[1:0];
      flags_q <= flags_d;
      mask_q  <= mask_d;
    end
  end

  codec_irq_drive u_drive (
    .clk(clk), .rst_n(rst_n),
    .flags_q(flags_q), .flags_d(flags_d), .set_vec(flag_set),
    .mask_q(mask_q[NFLAG-1:0]), .mask_d(mask_d[NFLAG-1:0]),
    .form_q(irq_form_e'(mask_q[7:6])), .form_d(irq_form_e'(mask_d[7:6])),
    .irq_o(irq_o));

  always_comb begin
    case (rd_addr)
      A_PWR:   rd_data = {6'b0, pwr_q};
      A_MUTE:  rd_data = {6'b0, mute_q};
      A_FLAG:  rd_data = {1'b0, jack_s, flags_q};
      default: rd_data = mask_q;
    endcase
  end

  // R2: a cleared flag with no simultaneous event is gone next cycle
  a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_clr & ~flag_set & flags_q)) |=>
      ((flags_q & $past(flag_clr & ~flag_set)) == '0));
  // R2: flags only fall through an explicit clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~$past(flag_clr) & ~flags_q) == '0));
  // R3: an event always lands, even against a clear
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));
  // R8: a jack edge reaches the flag register
  a_r8_jack_flag: assert property (@(posedge clk) disable iff (!rst_n)
    jack_evt |=> flags_q[5]);
endmodule

// File: tb/sim_codec_irq_seq.sv
`timescale 1ns/1ps
module sim_codec_irq_seq;
  localparam int HPL = 16;
  localparam int GNL = 12;
  localparam logic [1:0] PWR = 2'd0, MUTE = 2'd1, FLAG = 2'd2, MASK = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic       jack_in = 1'b0;
  logic       short_pulse = 1'b0;
  wire  [7:0] rd_data;
  wire        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  codec_irq_seq #(.HP_RAMP_LEN(HPL), .GAIN_RAMP_LEN(GNL), .JACK_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .jack_in(jack_in), .short_pulse(short_pulse), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    chk(tag, {7'b0, irq_o}, {7'b0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_short();
    @(negedge clk); short_pulse = 1'b1;
    @(negedge clk); short_pulse = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 power", PWR, 8'h03);
    rd_chk("R1 mute", MUTE, 8'h03);
    rd_chk("R1 flags", FLAG, 8'h00);
    rd_chk("R1 mask", MASK, 8'h3F);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_hp_ramp();
    wr(PWR, 8'h00);
    wr(MUTE, 8'h02);
    idle(HPL - 1); rd_chk("R4 before length", FLAG, 8'h00);
    idle(1);       rd_chk("R4 ramp-up flag", FLAG, 8'h08);
    wr(FLAG, 8'h08); rd_chk("R2 w1c", FLAG, 8'h00);
    wr(MUTE, 8'h03);
    idle(HPL - 1); rd_chk("R5 before length", FLAG, 8'h00);
    idle(1);       rd_chk("R5 ramp-down flag", FLAG, 8'h04);
    wr(FLAG, 8'h00); rd_chk("R2 write zero", FLAG, 8'h04);
    wr(FLAG, 8'h04); rd_chk("R2 clear", FLAG, 8'h00);
  endtask

  task automatic t_dac_ramp();
    wr(MUTE, 8'h01);
    idle(GNL - 1); rd_chk("R6 before length", FLAG, 8'h00);
    idle(1);       rd_chk("R6 gain-up", FLAG, 8'h02);
    wr(FLAG, 8'h02);
    wr(MUTE, 8'h03);
    idle(GNL); rd_chk("R6 gain-down", FLAG, 8'h01);
    wr(FLAG, 8'h01);
    wr(PWR, 8'h02);
    wr(MUTE, 8'h01);
    idle(GNL + 4); rd_chk("R6 standby ignored", FLAG, 8'h00);
    wr(MUTE, 8'h03);
    wr(PWR, 8'h00);
    wr(MUTE, 8'h01);
    idle(4);
    wr(PWR, 8'h02);
    idle(GNL + 4); rd_chk("R6 abort", FLAG, 8'h00);
    wr(PWR, 8'h01);
    wr(MUTE, 8'h00);
    idle(HPL + 4); rd_chk("R4 standby no up-ramp", FLAG, 8'h00);
    wr(MUTE, 8'h01);
    idle(HPL); rd_chk("R5 down-ramp in standby", FLAG, 8'h04);
    wr(FLAG, 8'h04);
    wr(PWR, 8'h00);
  endtask

  task automatic t_restart();
    // mute reg is 01: DAC unmuted, headphone muted
    wr(MUTE, 8'h03);
    idle(4);
    wr(MUTE, 8'h01);
    idle(GNL - 1); rd_chk("R7 before new length", FLAG, 8'h00);
    idle(1);       rd_chk("R7 new direction only", FLAG, 8'h02);
    wr(FLAG, 8'h02);
  endtask

  task automatic t_jack();
    @(negedge clk); jack_in = 1'b1;
    idle(4); rd_chk("R8 rise", FLAG, 8'h60);
    wr(FLAG, 8'h40); rd_chk("R2 bit6 read-only", FLAG, 8'h60);
    wr(FLAG, 8'h20); rd_chk("R8 clear keeps level", FLAG, 8'h40);
    @(negedge clk); jack_in = 1'b0;
    idle(4); rd_chk("R8 fall", FLAG, 8'h20);
    wr(FLAG, 8'h20);
  endtask

  task automatic t_short();
    pulse_short(); rd_chk("R9 short flag", FLAG, 8'h10);
    @(negedge clk);
    short_pulse = 1'b1; wr_en = 1'b1; wr_addr = FLAG; wr_data = 8'h10;
    @(negedge clk);
    short_pulse = 1'b0; wr_en = 1'b0;
    rd_chk("R3 set beats clear", FLAG, 8'h10);
    wr(FLAG, 8'h10); rd_chk("R2 clear after", FLAG, 8'h00);
  endtask

  task automatic t_mask();
    pulse_short(); irq_chk("R10 masked", 1'b0);
    wr(MASK, 8'h2F); irq_chk("R10 unmask pending", 1'b1);
    wr(MASK, 8'h6F); irq_chk("R11 active-low asserted", 1'b0);
    wr(FLAG, 8'h10); irq_chk("R11 active-low idle", 1'b1);
    wr(MASK, 8'h2F); irq_chk("R11 active-high idle", 1'b0);
    @(negedge clk); jack_in = 1'b1;
    idle(4); irq_chk("R10 jack masked", 1'b0);
    wr(MASK, 8'h0F); irq_chk("R10 jack unmasked", 1'b1);
    wr(FLAG, 8'h3F); irq_chk("R11 cleared", 1'b0);
  endtask

  task automatic t_pulse();
    wr(MASK, 8'h8F); irq_chk("R12 idle", 1'b0);
    pulse_short(); irq_chk("R12 high pulse", 1'b1);
    idle(1); irq_chk("R12 one clock", 1'b0);
    pulse_short(); irq_chk("R12 no repeat", 1'b0);
    wr(FLAG, 8'h10);
    wr(MASK, 8'hCF); irq_chk("R12 low idle", 1'b1);
    pulse_short(); irq_chk("R12 low pulse", 1'b0);
    idle(1); irq_chk("R12 low one clock", 1'b1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_hp_ramp();
    t_dac_ramp();
    t_restart();
    t_jack();
    t_short();
    t_mask();
    t_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule